// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer with LRU Refill

This block translates a logical address into a physical address. The upper bits of the incoming address form a page number and the low twelve bits form the offset within a 4 KB page. The page number is compared against every cached entry in parallel. On a match the block answers with the cached frame number placed above the unchanged offset, and it checks the access against that entry's read-only flag. The answer arrives one cycle after the request is accepted.

When no entry matches, the block asks an external page-table walker for the mapping. It presents the page number on a refill request and stalls further requests until the walker returns a frame number together with a read-only flag and a present flag. The returned mapping answers the stalled request. If the page is present, the mapping is also written into a free slot. When no slot is free, the least recently used slot is overwritten. A single-cycle flush drops every cached mapping, for example on a context switch.

Top module: `xlat_tlb`

## Requirements
- R1: The physical address equals the frame number (bits 29:12) placed above the request's low 12 offset bits (bits 11:0), which pass through unchanged. The page number is request address bits 31:12.
- R2: A request whose page matches a cached entry produces rsp_valid_o=1 with rsp_hit_o=1 in the cycle after acceptance. Fault code 0 means none. No refill request is raised.
- R3: A request that matches no entry produces no response on acceptance. In the next cycle miss_valid_o=1 with miss_page_o equal to the request's page number, and req_ready_o stays 0 until the refill arrives.
- R4: A refill while a miss is outstanding produces rsp_valid_o=1 and rsp_hit_o=0 in the next cycle, with the refilled frame as the physical frame. A present refill is cached, so a later request to the same page hits.
- R5: A write to a read-only mapping gives fault code 2 (protection), both on a hit and on a refill. A read of a read-only mapping gives code 0.
- R6: A refill with fill_present_i=0 gives fault code 1 (page fault) and is not cached, so the next request to that page misses again.
- R7: A refill goes into an empty slot while one exists. Eight distinct present refills after a flush all stay cached.
- R8: When all slots are occupied, a refill replaces the entry that was least recently hit or refilled.
- R9: While flush_i=1, req_ready_o=0. After the flush cycle no earlier mapping hits.
- R10: During and after reset, req_ready_o=1, rsp_valid_o=0, miss_valid_o=0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drop all cached mappings this cycle |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 32 | Logical address |
| req_write_i | input | 1 | Request is a write |
| rsp_valid_o | output | 1 | Response present (one cycle) |
| rsp_paddr_o | output | 30 | Physical address |
| rsp_hit_o | output | 1 | Response came from a cached entry |
| rsp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| miss_valid_o | output | 1 | Refill request outstanding |
| miss_page_o | output | 20 | Page number to be walked |
| fill_valid_i | input | 1 | Refill data present |
| fill_frame_i | input | 18 | Refilled frame number |
| fill_ro_i | input | 1 | Refilled mapping is read-only |
| fill_present_i | input | 1 | Refilled page is present |

## Verification
A hit response is due one cycle after the accepting edge. A refill request is visible one cycle after the accepting edge. The refill response follows the edge that carries the refill data by one cycle. The bench drives on falling edges and samples on the falling edge after each of those accepting or refill edges, so every value is read exactly one register stage after its cause. The LRU order is checked at the ports: the bench records the order in which pages were touched and then predicts which page must miss after an eviction. The flush stall is sampled before the flush edge and its effect after that edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned PA_W    = 30;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned ENTRIES = 8;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned KEY_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] slot_vld,
  input  logic [KEY_W-1:0]   slot_key [ENTRIES],
  input  logic [KEY_W-1:0]   key,
  output logic [ENTRIES-1:0] match_vec,
  output logic               match,
  output logic [IDX_W-1:0]   match_idx
);
  // one comparator per slot, all evaluated at once
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = slot_vld[g] && (slot_key[g] == key);
  end

  assign match = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] slot_vld,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  // rank 0 = most recently used, ENTRIES-1 = least; ranks form a permutation
  logic [IDX_W-1:0]   rank_q [ENTRIES];
  logic [IDX_W-1:0]   rank_d [ENTRIES];
  logic [ENTRIES-1:0] oldest_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      rank_d[i] = rank_q[i];
      if (touch_en) begin
        if (IDX_W'(i) == touch_idx)             rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx]) rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= rank_d[i];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest_vec[g] = (rank_q[g] == OLDEST);
  end

  // empty slot first (lowest index), otherwise the oldest slot
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!slot_vld[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (oldest_vec[i]) victim_idx = IDX_W'(i);
      end
    end
  end

  assert_single_oldest_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  assert_touch_newest_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (rank_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ADDR_W  = VA_W,
  parameter int unsigned PADDR_W = PA_W,
  parameter int unsigned PG_OFF  = OFF_W,
  parameter int unsigned SLOTS   = ENTRIES,
  localparam int unsigned PG_W   = ADDR_W - PG_OFF,
  localparam int unsigned FR_W   = PADDR_W - PG_OFF,
  localparam int unsigned IDX_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  output logic [PADDR_W-1:0] rsp_paddr_o,
  output logic               rsp_hit_o,
  output logic [1:0]         rsp_fault_o,
  output logic               miss_valid_o,
  output logic [PG_W-1:0]    miss_page_o,
  input  logic               fill_valid_i,
  input  logic [FR_W-1:0]    fill_frame_i,
  input  logic               fill_ro_i,
  input  logic               fill_present_i
);
  // cached entries
  logic [SLOTS-1:0] vld_q, vld_d;
  logic [PG_W-1:0]  tag_q [SLOTS];
  logic [FR_W-1:0]  frm_q [SLOTS];
  logic [SLOTS-1:0] ro_q;

  // outstanding miss
  logic              pend_q, pend_d;
  logic [PG_W-1:0]   pvpn_q, pvpn_d;
  logic [PG_OFF-1:0] poff_q, poff_d;
  logic              pwr_q, pwr_d;

  // response register
  logic               rv_q, rv_d;
  logic [PADDR_W-1:0] rpa_q, rpa_d;
  logic               rhit_q, rhit_d;
  fault_e             rflt_q, rflt_d;

  logic              accept;
  logic [PG_W-1:0]   req_vpn;
  logic [PG_OFF-1:0] req_off;
  logic [SLOTS-1:0]  hit_vec;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic              refill;
  logic              install_en;
  logic              touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign req_vpn     = req_addr_i[ADDR_W-1:PG_OFF];
  assign req_off     = req_addr_i[PG_OFF-1:0];
  assign req_ready_o = !pend_q && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign refill      = pend_q && fill_valid_i;
  assign install_en  = refill && fill_present_i;

  tlb_cam #(.ENTRIES(SLOTS), .KEY_W(PG_W)) u_cam (
    .slot_vld  (vld_q),
    .slot_key  (tag_q),
    .key       (req_vpn),
    .match_vec (hit_vec),
    .match     (hit),
    .match_idx (hit_idx)
  );

  assign touch_en  = (accept && hit) || install_en;
  assign touch_idx = install_en ? victim_idx : hit_idx;

  tlb_lru #(.ENTRIES(SLOTS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .slot_vld   (vld_q),
    .victim_idx (victim_idx)
  );

  // next state
  always_comb begin
    pend_d = pend_q;
    pvpn_d = pvpn_q;
    poff_d = poff_q;
    pwr_d  = pwr_q;
    rv_d   = 1'b0;
    rpa_d  = rpa_q;
    rhit_d = rhit_q;
    rflt_d = rflt_q;
    vld_d  = vld_q;

    if (accept && hit) begin
      rv_d   = 1'b1;
      rhit_d = 1'b1;
      rpa_d  = {frm_q[hit_idx], req_off};
      rflt_d = (req_write_i && ro_q[hit_idx]) ? FLT_PROT : FLT_NONE;
    end else if (accept) begin
      pend_d = 1'b1;
      pvpn_d = req_vpn;
      poff_d = req_off;
      pwr_d  = req_write_i;
    end

    if (refill) begin
      pend_d = 1'b0;
      rv_d   = 1'b1;
      rhit_d = 1'b0;
      rpa_d  = {fill_frame_i, poff_q};
      if (!fill_present_i)          rflt_d = FLT_PAGE;
      else if (pwr_q && fill_ro_i)  rflt_d = FLT_PROT;
      else                          rflt_d = FLT_NONE;
    end

    if (flush_i)    vld_d = '0;
    if (install_en) vld_d[victim_idx] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      pend_q <= 1'b0;
      pvpn_q <= '0;
      poff_q <= '0;
      pwr_q  <= 1'b0;
      rv_q   <= 1'b0;
      rpa_q  <= '0;
      rhit_q <= 1'b0;
      rflt_q <= FLT_NONE;
    end else begin
      vld_q  <= vld_d;
      pend_q <= pend_d;
      pvpn_q <= pvpn_d;
      poff_q <= poff_d;
      pwr_q  <= pwr_d;
      rv_q   <= rv_d;
      rpa_q  <= rpa_d;
      rhit_q <= rhit_d;
      rflt_q <= rflt_d;
    end
  end

  // entry payload, written only on install
  always_ff @(posedge clk) begin
    if (install_en) begin
      tag_q[victim_idx] <= pvpn_q;
      frm_q[victim_idx] <= fill_frame_i;
      ro_q[victim_idx]  <= fill_ro_i;
    end
  end

  assign rsp_valid_o  = rv_q;
  assign rsp_paddr_o  = rpa_q;
  assign rsp_hit_o    = rhit_q;
  assign rsp_fault_o  = rflt_q;
  assign miss_valid_o = pend_q;
  assign miss_page_o  = pvpn_q;

  assert_unique_match_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_hit_answer_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid_o && rsp_hit_o && !miss_valid_o));

  assert_miss_request_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (miss_valid_o && !rsp_valid_o));

  assert_stall_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_o |-> !req_ready_o);

  assert_refill_answer_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    refill |=> (rsp_valid_o && !rsp_hit_o && !miss_valid_o));

  assert_no_cache_absent_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (refill && !fill_present_i && !flush_i) |=> $stable(vld_q));

  assert_flush_empty_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !install_en) |=> (vld_q == '0));
endmodule

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, req_valid_i, req_write_i;
  logic        req_ready_o, rsp_valid_o, rsp_hit_o, miss_valid_o;
  logic [31:0] req_addr_i;
  logic [29:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic [19:0] miss_page_o;
  logic        fill_valid_i, fill_ro_i, fill_present_i;
  logic [17:0] fill_frame_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  xlat_tlb u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o),
    .rsp_hit_o(rsp_hit_o), .rsp_fault_o(rsp_fault_o),
    .miss_valid_o(miss_valid_o), .miss_page_o(miss_page_o),
    .fill_valid_i(fill_valid_i), .fill_frame_i(fill_frame_i),
    .fill_ro_i(fill_ro_i), .fill_present_i(fill_present_i)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [11:0] off;
    logic        wr;
    logic [17:0] ffr;
    logic        fro;
    logic        fpr;
    logic        ehit;
    logic [1:0]  eflt;
    logic [17:0] efr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{20'h00010, 12'h000, 1'b0, 18'h000A1, 1'b0, 1'b1, 1'b0, 2'd0, 18'h000A1},
    '{20'h00010, 12'hFFF, 1'b0, 18'h00000, 1'b0, 1'b0, 1'b1, 2'd0, 18'h000A1},
    '{20'h00020, 12'h123, 1'b1, 18'h000B2, 1'b1, 1'b1, 1'b0, 2'd2, 18'h000B2},
    '{20'h00020, 12'h456, 1'b0, 18'h00000, 1'b0, 1'b0, 1'b1, 2'd0, 18'h000B2},
    '{20'h00020, 12'h789, 1'b1, 18'h00000, 1'b0, 1'b0, 1'b1, 2'd2, 18'h000B2},
    '{20'h00030, 12'hABC, 1'b0, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 2'd1, 18'h3FFFF},
    '{20'h00030, 12'h001, 1'b0, 18'h000C3, 1'b0, 1'b1, 1'b0, 2'd0, 18'h000C3},
    '{20'h00030, 12'hFFE, 1'b1, 18'h00000, 1'b0, 1'b0, 1'b1, 2'd0, 18'h000C3},
    '{20'hFFFFF, 12'h800, 1'b0, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 2'd0, 18'h3FFFF},
    '{20'hFFFFF, 12'h7FF, 1'b1, 18'h00000, 1'b0, 1'b0, 1'b1, 2'd0, 18'h3FFFF}
  };

  // results of the last access
  logic        g_hit, g_miss, g_rv;
  logic [1:0]  g_flt;
  logic [29:0] g_pa;
  logic [19:0] g_mpg;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one request; on a miss the given refill is supplied
  task automatic access(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                        input logic [17:0] ffr, input logic fro, input logic fpr);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_addr_i  = {vpn, off};
    req_write_i = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    g_miss = !rsp_valid_o;
    g_mpg  = miss_page_o;
    if (g_miss) begin
      check(miss_valid_o && !req_ready_o, "R3 miss raised and stalled",
            {30'd0, miss_valid_o, req_ready_o}, 32'h2);
      fill_valid_i   = 1'b1;
      fill_frame_i   = ffr;
      fill_ro_i      = fro;
      fill_present_i = fpr;
      @(posedge clk);
      @(negedge clk);
      fill_valid_i = 1'b0;
    end
    g_rv  = rsp_valid_o;
    g_hit = rsp_hit_o;
    g_flt = rsp_fault_o;
    g_pa  = rsp_paddr_o;
  endtask

  task automatic expect_hit(input logic [19:0] vpn, input logic [17:0] frm, input string rq);
    access(vpn, 12'h0A5, 1'b0, 18'h0, 1'b0, 1'b1);
    check(!g_miss && g_rv && g_hit && g_pa == {frm, 12'h0A5}, rq,
          {g_hit, g_pa[29:0], g_miss}, {1'b1, frm, 12'h0A5, 1'b0});
  endtask

  task automatic expect_miss(input logic [19:0] vpn, input logic [17:0] frm, input string rq);
    access(vpn, 12'h05A, 1'b0, frm, 1'b0, 1'b1);
    check(g_miss && g_mpg == vpn && g_rv && !g_hit && g_pa == {frm, 12'h05A}, rq,
          {11'd0, g_mpg, g_miss}, {11'd0, vpn, 1'b1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    flush_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0; req_addr_i = '0;
    fill_valid_i = 1'b0; fill_frame_i = '0; fill_ro_i = 1'b0; fill_present_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(req_ready_o && !rsp_valid_o && !miss_valid_o, "R10 reset outputs",
          {29'd0, req_ready_o, rsp_valid_o, miss_valid_o}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !miss_valid_o, "R10 after release",
          {29'd0, req_ready_o, rsp_valid_o, miss_valid_o}, 32'h4);

    // vector table: R1 R2 R3 R4 R5 R6 (first access also shows R10 empty cache)
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].vpn, VEC[i].off, VEC[i].wr, VEC[i].ffr, VEC[i].fro, VEC[i].fpr);
      check(g_miss == !VEC[i].ehit, "R2/R3 hit or miss",
            {31'd0, g_miss}, {31'd0, !VEC[i].ehit});
      if (g_miss)
        check(g_mpg == VEC[i].vpn, "R3 refill page", {12'd0, g_mpg}, {12'd0, VEC[i].vpn});
      check(g_rv && g_hit == VEC[i].ehit, "R4 response flag",
            {30'd0, g_rv, g_hit}, {30'd0, 1'b1, VEC[i].ehit});
      check(g_flt == VEC[i].eflt, "R5/R6 fault code", {30'd0, g_flt}, {30'd0, VEC[i].eflt});
      check(g_pa == {VEC[i].efr, VEC[i].off}, "R1 physical address",
            {2'd0, g_pa}, {2'd0, VEC[i].efr, VEC[i].off});
    end

    // R9 flush: stall during flush, then earlier mappings miss
    @(negedge clk);
    flush_i = 1'b1;
    #1;
    check(!req_ready_o, "R9 ready low in flush", {31'd0, req_ready_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    flush_i = 1'b0;
    expect_miss(20'h00010, 18'h000D1, "R9 page 0x10 misses after flush");
    expect_miss(20'h00020, 18'h000D2, "R9 page 0x20 misses after flush");

    // R7: eight refills after a flush all stay cached
    @(negedge clk);
    flush_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush_i = 1'b0;
    for (int i = 0; i < 8; i++)
      expect_miss(20'h00100 + 20'(i), 18'h00100 + 18'(i), "R7 initial refill");
    for (int i = 0; i < 8; i++)
      expect_hit(20'h00100 + 20'(i), 18'h00100 + 18'(i), "R7 all eight cached");

    // R8: order now P0 oldest; hit P0 makes P1 oldest
    expect_hit(20'h00100, 18'h00100, "R8 touch P0");
    expect_miss(20'h00200, 18'h00200, "R8 new page evicts P1");
    expect_miss(20'h00101, 18'h00101, "R8 P1 was evicted");
    expect_hit(20'h00100, 18'h00100, "R8 P0 survived");
    expect_miss(20'h00102, 18'h00102, "R8 P2 was evicted");
    expect_hit(20'h00200, 18'h00200, "R8 new page still cached");

    // R6: absent page stays uncached, R5 read of read-only is clean
    access(20'h00300, 12'h010, 1'b0, 18'h00300, 1'b1, 1'b0);
    check(g_miss && g_flt == 2'd1, "R6 page fault on absent", {30'd0, g_flt}, 32'd1);
    access(20'h00300, 12'h010, 1'b0, 18'h00300, 1'b1, 1'b1);
    check(g_miss && g_flt == 2'd0, "R6 absent page not cached / R5 read ok",
          {30'd0, g_flt}, 32'd0);
    access(20'h00300, 12'h011, 1'b1, 18'h0, 1'b0, 1'b1);
    check(!g_miss && g_hit && g_flt == 2'd2, "R5 write to read-only hit",
          {30'd0, g_flt}, 32'd2);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule